// File: doc/BRIEF.md
# Secure-module start-up sequencer

This block brings a TPM-style security device from power-on to a usable state over a simple register-transaction master. After a start pulse it reads the device identifier word and compares it against a table of accepted values. If there is no match, it retries at a fixed interval. Once the device is recognised, it waits until locality 0 is free, claims it with a single request bit, and confirms the claim by reading the access byte back. It then checks that the status word reports the 2.0 family. Last, it fetches the revision byte.

The block raises `ready` and presents the vendor, device and revision values when all steps succeed. Any failure raises `error`. Either result holds until the next start. Only one register request is outstanding at a time, and it is held steady until the target answers. The register transport itself and all command traffic belong to neighbouring blocks.

Top module: `tpm_probe`

## Requirements
- R1: While reset is asserted and after its release, `ready`, `error` and `req_valid` are 0, and `vendor_id`, `device_id` and `revision` are 0 until a sequence completes.
- R2: A start pulse with the block idle, done or failed issues a read (`req_write`=0) of length 4 at offset 0xF00. Every request uses one of these forms: identifier read (0xF00, 4), access read or write (0x000, 1), status read (0x018, 4), or revision read (0xF04, 1).
- R3: An identifier response that matches no table entry, or that carries `rsp_err` (its data is then ignored), is followed by exactly RETRY_GAP cycles with `req_valid` low, and then by another identifier read.
- R4: After RETRY_MAX identifier reads without a match, the block raises `error` and issues no further request.
- R5: After success, `vendor_id` equals bits [15:0] and `device_id` equals bits [31:16] of the matched identifier, and `revision` equals `rsp_rdata[7:0]` of the revision read.
- R6: Once the identifier matches, the block reads the access byte from `rsp_rdata[7:0]` and clears bit 0 (establishment) in it. If bit 5 (locality active) is then set, `req_valid` stays low for exactly BUSY_GAP cycles and the access byte is read again. A transport error on this read counts as a zero byte.
- R7: CLAIM_LIMIT cycles after the first access read is issued, a wait that would lead to another read ends with `error`, and no write is issued.
- R8: When the access byte shows the locality free, the block issues exactly one write at offset 0x000 of length 1 with data 0x02 (bit 1 only, request-use).
- R9: After the write, the block reads the access byte again. If the byte, with bit 0 masked, is not exactly 0xA0 (bit 7 valid plus bit 5 active), the block raises `error`.
- R10: After the claim, the block reads the status word. If bits [27:26] are not 2'b01, it raises `error` and makes no revision read.
- R11: `rsp_err` on the request-use write, on the claim read-back, on the status read or on the revision read raises `error`.
- R12: `ready` and `error` are never high together, and each holds until the next start. A start pulse during a running sequence has no effect. A start pulse afterwards clears both flags on the next cycle.
- R13: While `req_valid` is high and no response has arrived, `req_valid`, `req_write`, `req_addr` and `req_len` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin (or restart) the start-up sequence |
| req_valid | output | 1 | Register request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | ADDR_W | Register offset |
| req_len | output | 3 | Transfer length in bytes |
| req_wdata | output | DATA_W | Write data, byte 0 in bits [7:0] |
| rsp_valid | input | 1 | One-cycle response strobe for the pending request |
| rsp_err | input | 1 | Transport failure for this response |
| rsp_rdata | input | DATA_W | Read data, byte 0 in bits [7:0] |
| ready | output | 1 | Sequence completed successfully |
| error | output | 1 | Sequence failed |
| vendor_id | output | 16 | Captured vendor identifier |
| device_id | output | 16 | Captured device identifier |
| revision | output | 8 | Captured revision byte |

## Verification
The assertions assume that the register target raises `rsp_valid` only while a request is pending, for one cycle per request, and never while the block is idle, done or failed. The assertions also rely on `start` being a clean single-cycle pulse. The bench's target model follows that contract: it accepts a request only when `req_valid` is high, answers after a fixed latency with a single strobe, and drops the strobe on the next cycle. The sweep varies the identifier, failure counts, busy-read counts, read-back bytes, family codes and error injection points one axis at a time. Restarts occur only when the block is done or failed, apart from one deliberate mid-run pulse.

// File: rtl/tpm_probe_pkg.sv
package tpm_probe_pkg;

    localparam int ATT_W = 8;

    localparam logic [15:0] OFS_ACCESS   = 16'h0000;
    localparam logic [15:0] OFS_STATUS   = 16'h0018;
    localparam logic [15:0] OFS_IDENT    = 16'h0F00;
    localparam logic [15:0] OFS_REVISION = 16'h0F04;

    localparam int ACC_ESTAB_BIT  = 0;
    localparam int ACC_REQUSE_BIT = 1;
    localparam int ACC_ACTIVE_BIT = 5;
    localparam int ACC_VALID_BIT  = 7;

    localparam int          FAMILY_LSB = 26;
    localparam logic [1:0]  FAMILY_V2  = 2'b01;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ID_RD,
        PH_ID_GAP,
        PH_ACC_RD,
        PH_BUSY_GAP,
        PH_REQ_WR,
        PH_CHK_RD,
        PH_STS_RD,
        PH_RID_RD,
        PH_DONE,
        PH_FAIL
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [ATT_W-1:0]   attempts;
        logic [15:0]        vid;
        logic [15:0]        did;
        logic [7:0]         rev;
        logic               ready;
        logic               error;
    } probe_state_t;

endpackage

// File: rtl/tpm_probe_timer.sv
module tpm_probe_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/tpm_probe_idmatch.sv
module tpm_probe_idmatch #(
    parameter int                  ID_W    = 32,
    parameter int                  NUM_IDS = 3,
    parameter logic [NUM_IDS*ID_W-1:0] TABLE = '0
) (
    input  logic [ID_W-1:0] ident,
    output logic            hit
);

    logic [NUM_IDS-1:0] hits;

    generate
        for (genvar gi = 0; gi < NUM_IDS; gi++) begin : g_entry
            assign hits[gi] = (ident == TABLE[gi*ID_W +: ID_W]);
        end
    endgenerate

    assign hit = |hits;

endmodule

// File: rtl/tpm_probe.sv
module tpm_probe
    import tpm_probe_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int NUM_IDS     = 3,
    parameter logic [NUM_IDS*DATA_W-1:0] ACCEPT_IDS =
        {32'h6610_00FF, 32'h0B4E_7291, 32'hA5C3_1D07},
    parameter int RETRY_MAX   = 15,
    parameter int RETRY_GAP   = 1_000_000,
    parameter int BUSY_GAP    = 200_000,
    parameter int CLAIM_LIMIT = 1_000_000_000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    output logic                         req_valid,
    output logic                         req_write,
    output logic [ADDR_W-1:0]            req_addr,
    output logic [$clog2(DATA_W/8+1)-1:0] req_len,
    output logic [DATA_W-1:0]            req_wdata,
    input  logic                         rsp_valid,
    input  logic                         rsp_err,
    input  logic [DATA_W-1:0]            rsp_rdata,
    output logic                         ready,
    output logic                         error,
    output logic [15:0]                  vendor_id,
    output logic [15:0]                  device_id,
    output logic [7:0]                   revision
);

    localparam int LEN_W   = $clog2(DATA_W/8+1);
    localparam int GAP_MAX = (RETRY_GAP > BUSY_GAP) ? RETRY_GAP : BUSY_GAP;
    localparam int GAP_W   = $clog2(GAP_MAX + 1);
    localparam int CLM_W   = $clog2(CLAIM_LIMIT + 1);
    localparam logic [7:0] ESTAB_MASK  = 8'(1 << ACC_ESTAB_BIT);
    localparam logic [7:0] CLAIMED_VAL = 8'((1 << ACC_VALID_BIT) | (1 << ACC_ACTIVE_BIT));

    probe_state_t st_d, st_q;

    logic              gap_load;
    logic [GAP_W-1:0]  gap_val;
    logic              gap_exp;
    logic              claim_load;
    logic              claim_exp;
    logic              id_hit;
    logic [DATA_W-1:0] rd_word;
    logic [7:0]        acc_byte;
    logic [ATT_W-1:0]  att_next;

    // transport failure reads as zero
    assign rd_word  = rsp_err ? '0 : rsp_rdata;
    assign acc_byte = rd_word[7:0] & ~ESTAB_MASK;
    assign att_next = st_q.attempts + 1'b1;

    tpm_probe_idmatch #(
        .ID_W    (DATA_W),
        .NUM_IDS (NUM_IDS),
        .TABLE   (ACCEPT_IDS)
    ) idmatch_i (
        .ident (rd_word),
        .hit   (id_hit)
    );

    tpm_probe_timer #(.W(GAP_W)) gap_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .expired  (gap_exp)
    );

    tpm_probe_timer #(.W(CLM_W)) claim_tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (claim_load),
        .load_val (CLM_W'(CLAIM_LIMIT)),
        .expired  (claim_exp)
    );

    always_comb begin
        st_d       = st_q;
        gap_load   = 1'b0;
        gap_val    = '0;
        claim_load = 1'b0;

        unique case (st_q.phase)
            PH_IDLE, PH_DONE, PH_FAIL: begin
                if (start) begin
                    st_d.phase    = PH_ID_RD;
                    st_d.attempts = '0;
                    st_d.ready    = 1'b0;
                    st_d.error    = 1'b0;
                end
            end
            PH_ID_RD: begin
                if (rsp_valid) begin
                    st_d.attempts = att_next;
                    if (id_hit) begin
                        st_d.vid   = rd_word[15:0];
                        st_d.did   = rd_word[31:16];
                        st_d.phase = PH_ACC_RD;
                        claim_load = 1'b1;
                    end else if (att_next >= ATT_W'(RETRY_MAX)) begin
                        st_d.phase = PH_FAIL;
                        st_d.error = 1'b1;
                    end else begin
                        st_d.phase = PH_ID_GAP;
                        gap_load   = 1'b1;
                        gap_val    = GAP_W'(RETRY_GAP - 1);
                    end
                end
            end
            PH_ID_GAP: begin
                if (gap_exp) begin
                    st_d.phase = PH_ID_RD;
                end
            end
            PH_ACC_RD: begin
                if (rsp_valid) begin
                    if (acc_byte[ACC_ACTIVE_BIT]) begin
                        st_d.phase = PH_BUSY_GAP;
                        gap_load   = 1'b1;
                        gap_val    = GAP_W'(BUSY_GAP - 1);
                    end else begin
                        st_d.phase = PH_REQ_WR;
                    end
                end
            end
            PH_BUSY_GAP: begin
                if (gap_exp) begin
                    if (claim_exp) begin
                        st_d.phase = PH_FAIL;
                        st_d.error = 1'b1;
                    end else begin
                        st_d.phase = PH_ACC_RD;
                    end
                end
            end
            PH_REQ_WR: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        st_d.phase = PH_FAIL;
                        st_d.error = 1'b1;
                    end else begin
                        st_d.phase = PH_CHK_RD;
                    end
                end
            end
            PH_CHK_RD: begin
                if (rsp_valid) begin
                    if (rsp_err || (acc_byte != CLAIMED_VAL)) begin
                        st_d.phase = PH_FAIL;
                        st_d.error = 1'b1;
                    end else begin
                        st_d.phase = PH_STS_RD;
                    end
                end
            end
            PH_STS_RD: begin
                if (rsp_valid) begin
                    if (rsp_err || (rsp_rdata[FAMILY_LSB +: 2] != FAMILY_V2)) begin
                        st_d.phase = PH_FAIL;
                        st_d.error = 1'b1;
                    end else begin
                        st_d.phase = PH_RID_RD;
                    end
                end
            end
            PH_RID_RD: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        st_d.phase = PH_FAIL;
                        st_d.error = 1'b1;
                    end else begin
                        st_d.rev   = rsp_rdata[7:0];
                        st_d.phase = PH_DONE;
                        st_d.ready = 1'b1;
                    end
                end
            end
            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, attempts: '0, vid: '0, did: '0,
                      rev: '0, ready: 1'b0, error: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // request decode
    always_comb begin
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = ADDR_W'(OFS_ACCESS);
        req_len   = LEN_W'(1);
        req_wdata = '0;
        unique case (st_q.phase)
            PH_ID_RD: begin
                req_valid = 1'b1;
                req_addr  = ADDR_W'(OFS_IDENT);
                req_len   = LEN_W'(4);
            end
            PH_ACC_RD, PH_CHK_RD: begin
                req_valid = 1'b1;
            end
            PH_REQ_WR: begin
                req_valid = 1'b1;
                req_write = 1'b1;
                req_wdata = DATA_W'(1 << ACC_REQUSE_BIT);
            end
            PH_STS_RD: begin
                req_valid = 1'b1;
                req_addr  = ADDR_W'(OFS_STATUS);
                req_len   = LEN_W'(4);
            end
            PH_RID_RD: begin
                req_valid = 1'b1;
                req_addr  = ADDR_W'(OFS_REVISION);
            end
            default: begin
                req_valid = 1'b0;
            end
        endcase
    end

    assign ready     = st_q.ready;
    assign error     = st_q.error;
    assign vendor_id = st_q.vid;
    assign device_id = st_q.did;
    assign revision  = st_q.rev;

endmodule

// File: rtl/tpm_probe_chk.sv
module tpm_probe_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start,
    input logic                          req_valid,
    input logic                          req_write,
    input logic [ADDR_W-1:0]             req_addr,
    input logic [$clog2(DATA_W/8+1)-1:0] req_len,
    input logic [DATA_W-1:0]             req_wdata,
    input logic                          rsp_valid,
    input logic                          ready,
    input logic                          error
);

    localparam int LEN_W = $clog2(DATA_W/8+1);

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr)
                                       && $stable(req_write) && $stable(req_len)));

    assert_flags_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready && error));

    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    assert_rdy_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> ready);

    assert_quiet_after_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (error || ready) |-> !req_valid);

    assert_write_form_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> (req_addr == '0 && req_len == LEN_W'(1)
                                      && req_wdata == DATA_W'(2)));

    assert_ready_after_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(rsp_valid));

endmodule

bind tpm_probe tpm_probe_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .ready     (ready),
    .error     (error)
);

// File: tb/tpm_probe_tb_top.sv
module tpm_probe_tb_top;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int NIDS   = 3;
    localparam logic [NIDS*32-1:0] TBL = {32'h6610_00FF, 32'h0B4E_7291, 32'hA5C3_1D07};
    localparam int RMAX   = 15;
    localparam int RGAP   = 5;
    localparam int BGAP   = 7;
    localparam int CLIM   = 80;
    localparam int LAT    = 2;

    localparam int K_NONE = 0, K_ID = 1, K_ACC = 2, K_ACCB = 3, K_WR = 4,
                   K_STS = 5, K_RID = 6, K_BAD = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic req_valid, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [2:0] req_len;
    logic [DATA_W-1:0] req_wdata;
    logic rsp_valid = 1'b0;
    logic rsp_err = 1'b0;
    logic [DATA_W-1:0] rsp_rdata = '0;
    logic ready, error;
    logic [15:0] vendor_id, device_id;
    logic [7:0] revision;

    always #4 clk = ~clk;

    tpm_probe #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_IDS(NIDS), .ACCEPT_IDS(TBL),
        .RETRY_MAX(RMAX), .RETRY_GAP(RGAP), .BUSY_GAP(BGAP), .CLAIM_LIMIT(CLIM)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ready(ready), .error(error),
        .vendor_id(vendor_id), .device_id(device_id), .revision(revision)
    );

    // case configuration (written by the stimulus only)
    int          case_no = 0;
    logic [31:0] cfg_id = '0;
    int          cfg_fails = 0;
    int          cfg_busy = 0;
    logic [7:0]  cfg_rb = 8'hA0;
    logic [1:0]  cfg_fam = 2'b01;
    int          cfg_errat = 0;
    logic        cfg_est = 1'b0;

    // target model state and counters (written by the model only)
    int seen_case = 0;
    int id_k = 0, busy_left = 0, acc_reads = 0, chk_reads = 0, wr_count = 0;
    int sts_reads = 0, rid_reads = 0, gap_bad = 0, fmt_bad = 0, n_req = 0;
    int gap = 0, prev_kind = 0, kind = 0, lat_cnt = 0;
    bit inflight = 1'b0, claimed = 1'b0;
    logic [31:0] last_wdata = '0;

    always @(negedge clk) begin
        if (case_no != seen_case) begin
            seen_case = case_no;
            id_k = 0; busy_left = cfg_busy; acc_reads = 0; chk_reads = 0;
            wr_count = 0; sts_reads = 0; rid_reads = 0; gap_bad = 0; fmt_bad = 0;
            n_req = 0; gap = 0; prev_kind = K_NONE; claimed = 1'b0; inflight = 1'b0;
        end
        if (!req_valid) gap++;
        if (rsp_valid) begin
            rsp_valid = 1'b0;
            rsp_err   = 1'b0;
        end else if (req_valid) begin
            if (!inflight) begin
                inflight = 1'b1;
                lat_cnt  = 0;
                n_req++;
                if (req_write)
                    kind = (req_addr == 16'h0000 && req_len == 3'd1) ? K_WR : K_BAD;
                else if (req_addr == 16'h0F00 && req_len == 3'd4) kind = K_ID;
                else if (req_addr == 16'h0000 && req_len == 3'd1) kind = K_ACC;
                else if (req_addr == 16'h0018 && req_len == 3'd4) kind = K_STS;
                else if (req_addr == 16'h0F04 && req_len == 3'd1) kind = K_RID;
                else kind = K_BAD;
                if (kind == K_BAD) fmt_bad++;
                if (kind == K_ID && prev_kind == K_ID && gap != RGAP) gap_bad++;
                if (kind == K_ACC && prev_kind == K_ACCB && gap != BGAP) gap_bad++;
                gap = 0;
            end
            if (lat_cnt == LAT) begin
                inflight  = 1'b0;
                rsp_valid = 1'b1;
                rsp_err   = 1'b0;
                rsp_rdata = '0;
                prev_kind = kind;
                case (kind)
                    K_ID: begin
                        if (id_k < cfg_fails) begin
                            if (id_k % 2 == 1) begin
                                rsp_err = 1'b1; rsp_rdata = cfg_id;
                            end else begin
                                rsp_rdata = 32'h1357_9BDF;
                            end
                        end else begin
                            rsp_rdata = cfg_id;
                        end
                        id_k++;
                    end
                    K_ACC: begin
                        if (!claimed) begin
                            acc_reads++;
                            if (busy_left > 0) begin
                                busy_left--;
                                rsp_rdata = {24'hC3C3C3, 7'b1010000, cfg_est};
                                prev_kind = K_ACCB;
                            end else begin
                                rsp_rdata = {24'hC3C3C3, 8'h81};
                            end
                        end else begin
                            chk_reads++;
                            rsp_rdata = {24'hC3C3C3, cfg_rb};
                        end
                    end
                    K_WR: begin
                        wr_count++;
                        last_wdata = req_wdata;
                        claimed = 1'b1;
                        rsp_err = (cfg_errat == 1);
                    end
                    K_STS: begin
                        sts_reads++;
                        rsp_rdata = {4'hA, cfg_fam, 26'h2AA_AAAA};
                        rsp_err = (cfg_errat == 2);
                    end
                    K_RID: begin
                        rid_reads++;
                        rsp_rdata = {24'hC3C3C3, cfg_id[7:0] ^ 8'h5A};
                        rsp_err = (cfg_errat == 3);
                    end
                    default: rsp_rdata = '0;
                endcase
            end else begin
                lat_cnt++;
            end
        end
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_case(input logic [31:0] id, input int fails, input int busy,
                            input logic [7:0] rb, input logic [1:0] fam,
                            input int errat, input logic est, input bit mid);
        bit ok_id, exp_err;
        int exp_idr, w, req_snap;
        @(negedge clk);
        cfg_id = id; cfg_fails = fails; cfg_busy = busy; cfg_rb = rb;
        cfg_fam = fam; cfg_errat = errat; cfg_est = est;
        case_no++;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!ready && !error, "R12 flags cleared by start", {ready, error}, 0);
        if (mid) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        w = 0;
        while (!(ready || error) && w < 20000) begin
            @(negedge clk);
            w++;
        end
        ok_id = 1'b0;
        for (int i = 0; i < NIDS; i++) if (TBL[i*32 +: 32] == id) ok_id = 1'b1;
        exp_idr = (ok_id && fails < RMAX) ? fails + 1 : RMAX;
        chk(id_k == exp_idr, "R3 identifier read count", id_k, exp_idr);
        chk(gap_bad == 0, "R3 R6 idle gap length", gap_bad, 0);
        chk(fmt_bad == 0, "R2 request form", fmt_bad, 0);
        exp_err = 1'b1;
        if (!ok_id || fails >= RMAX) begin
            chk(acc_reads == 0, "R4 no access read after retries", acc_reads, 0);
        end else if (busy >= 1000) begin
            chk(wr_count == 0, "R7 no write after claim timeout", wr_count, 0);
            chk(acc_reads >= CLIM / (LAT + 2 + BGAP), "R7 busy polling count",
                acc_reads, CLIM / (LAT + 2 + BGAP));
        end else begin
            chk(acc_reads == busy + 1, "R6 access reads before claim", acc_reads, busy + 1);
            chk(wr_count == 1 && last_wdata == 32'h2, "R8 request-use write",
                last_wdata, 2);
            if (errat == 1) begin
                chk(chk_reads == 0, "R11 write error stops", chk_reads, 0);
            end else begin
                chk(chk_reads == 1, "R9 read-back issued", chk_reads, 1);
                if ((rb & 8'hFE) != 8'hA0) begin
                    chk(sts_reads == 0, "R9 bad read-back stops", sts_reads, 0);
                end else begin
                    chk(sts_reads == 1, "R10 status read issued", sts_reads, 1);
                    if (fam != 2'b01 || errat == 2) begin
                        chk(rid_reads == 0, "R10 R11 status failure stops", rid_reads, 0);
                    end else begin
                        chk(rid_reads == 1, "R5 revision read issued", rid_reads, 1);
                        if (errat != 3) begin
                            exp_err = 1'b0;
                            chk(vendor_id == id[15:0], "R5 vendor", vendor_id, id[15:0]);
                            chk(device_id == id[31:16], "R5 device", device_id, id[31:16]);
                            chk(revision == (id[7:0] ^ 8'h5A), "R5 revision",
                                revision, id[7:0] ^ 8'h5A);
                        end
                    end
                end
            end
        end
        chk(error == exp_err && ready == !exp_err, "R4 R11 outcome",
            {ready, error}, {!exp_err, exp_err});
        req_snap = n_req;
        repeat (20) @(negedge clk);
        chk(n_req == req_snap, "R4 no request after finish", n_req, req_snap);
        chk(error == exp_err && ready == !exp_err, "R12 result held",
            {ready, error}, {!exp_err, exp_err});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!ready && !error && !req_valid, "R1 reset outputs", {ready, error, req_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!ready && !error && !req_valid && vendor_id == 0 && device_id == 0 && revision == 0,
            "R1 idle after reset", {ready, error, req_valid}, 0);

        for (int i = 0; i < NIDS; i++) begin
            run_case(TBL[i*32 +: 32], 0, 1, 8'hA0, 2'b01, 0, 1'b0, 1'b0);
            run_case(TBL[i*32 +: 32], 1, 1, 8'hA0, 2'b01, 0, 1'b0, 1'b0);
            run_case(TBL[i*32 +: 32], 2, 1, 8'hA0, 2'b01, 0, 1'b0, 1'b0);
            run_case(TBL[i*32 +: 32], RMAX - 1, 1, 8'hA0, 2'b01, 0, 1'b0, 1'b0);
            run_case(TBL[i*32 +: 32], RMAX, 1, 8'hA0, 2'b01, 0, 1'b0, 1'b0);
        end
        run_case(32'h0BAD_F00D, 0, 0, 8'hA0, 2'b01, 0, 1'b0, 1'b0);
        for (int b = 0; b < 5; b++) begin
            run_case(TBL[31:0], 0, b, 8'hA0, 2'b01, 0, 1'b0, 1'b0);
            run_case(TBL[63:32], 0, b, 8'hA1, 2'b01, 0, 1'b1, 1'b0);
        end
        begin
            logic [7:0] rbs [8] = '{8'h80, 8'hA0, 8'hA1, 8'hA2, 8'h20, 8'hE0, 8'h00, 8'h21};
            for (int r = 0; r < 8; r++)
                run_case(TBL[95:64], 1, 0, rbs[r], 2'b01, 0, 1'b0, 1'b0);
        end
        for (int f = 0; f < 4; f++)
            run_case(TBL[31:0], 0, 0, 8'hA0, 2'(f), 0, 1'b0, 1'b0);
        for (int e = 1; e < 4; e++)
            run_case(TBL[63:32], 0, 1, 8'hA0, 2'b01, e, 1'b0, 1'b0);
        run_case(TBL[31:0], 0, 100000, 8'hA0, 2'b01, 0, 1'b0, 1'b0);
        run_case(TBL[95:64], 2, 2, 8'hA0, 2'b01, 0, 1'b0, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R12 watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule